// File: doc/BRIEF.md
# Three-Phase Serialized Scan Engine

This engine sits on the debug probe side of a two-wire debug link. It carries the three JTAG data signals (TMS, TDI and TDO) over one shared data line plus a clock line. The clock line is called TCKC and the shared line TMSC. A request supplies a TMS vector, a TDI vector and a count of logical bits. For every logical bit the engine produces three TCKC periods. In the first it drives the inverted TDI bit. In the second it drives the TMS bit. In the third it stops driving, and the target returns its TDO bit.

The returned bits are gathered into an output vector, with the first bit in bit 0. The probe pin is modelled as a separate output value, output enable and input sample, so the pad can be placed outside the block. A request also carries a divider setting. The setting is the length of each TCKC half period in system clocks, and it is clamped so that TCKC never runs slower than 500 kHz. Escape sequences and link activation are handled elsewhere.

Top module: `tps_engine`

## Requirements
- R1: After reset, busy, done, tckc, tmscOe and tdoVec are all 0, and tckc stays low whenever the engine is idle.
- R2: Each logical bit takes exactly three TCKC periods, and each period is a low half followed by a high half. In the first period TMSC carries the inverse of the TDI bit with tmscOe=1. In the second it carries the TMS bit with tmscOe=1. Driven values are stable across each rising edge.
- R3: During the whole third period of every logical bit, tmscOe is 0, so the target owns the line.
- R4: The TDO bit is sampled from tmscIn on the falling TCKC edge that ends the third period. The i-th returned bit lands in tdoVec[i]. Bits at and above the processed count read 0.
- R5: Each TCKC half period lasts H system clocks. H is divReq, except that a divReq of 0 gives H=1.
- R6: H is capped at SYS_HZ/(2*MIN_TCK_HZ), which is 100 for the defaults, so TCKC never drops below 500 kHz.
- R7: busy rises on the clock after an accepted start and stays high for exactly 6*H*N system clocks, where N is the processed bit count. done is high for exactly one clock, in the first cycle with busy low.
- R8: A start with bitCount=0 is not accepted. A bitCount above MAX_BITS (32) is processed as MAX_BITS bits.
- R9: A start while busy has no effect on the running request: its length, driven bits and returned vector are unchanged.
- R10: Bit 0 of tmsVec and tdiVec is sent first. Bit i is sent as the (i+1)-th logical bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when idle and bitCount is not 0 |
| tmsVec | input | MAX_BITS | TMS bits, bit 0 sent first |
| tdiVec | input | MAX_BITS | TDI bits, bit 0 sent first |
| bitCount | input | $clog2(MAX_BITS+1) | Number of logical bits |
| divReq | input | DIV_W | Requested TCKC half period in system clocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| tdoVec | output | MAX_BITS | Captured TDO bits, bit 0 first |
| tckc | output | 1 | Serial link clock |
| tmscOut | output | 1 | Value driven onto TMSC |
| tmscOe | output | 1 | TMSC output enable |
| tmscIn | input | 1 | Sampled TMSC line level |

## Verification
The bench models the target. On each rising TCKC edge it checks which of the three periods is active. It checks the inverted TDI or the TMS value, or it checks that the probe has released the line. Then it drives its own TDO bit. An engine that drove TDI without inversion, or swapped the first two periods, would fail the per-edge comparison. An engine that kept tmscOe high in the third period would be caught at the rising edge of that period.

Every TCKC edge is timed against the clamped half period, using requests with divider settings of 0, 1, 2, 3 and 1000. A missing clamp or a missing zero guard would show up as a wrong edge spacing and a wrong busy length. The bench also targets the bit-count corners: a zero count that must be ignored, a count above 32 that must shrink to 32, and a full 32-bit vector. An unmasked capture would leave stale upper TDO bits set. A start landing mid-request must change nothing in the running request.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    PH_NTDI = 2'd0,
    PH_TMS  = 2'd1,
    PH_TDO  = 2'd2
  } phase_e;

  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // sample TDO and advance to next logical bit
    logic driveEn;  // probe owns TMSC
    logic selTdi;   // first period: drive inverted TDI
  } dpStrobe_t;

endpackage

// File: rtl/tps_divider.sv
module tps_divider #(
  parameter int SYS_HZ     = 100_000_000,
  parameter int MIN_TCK_HZ = 500_000,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] divReq,
  output logic             tick
);
  localparam int HALF_MAX = SYS_HZ / (2 * MIN_TCK_HZ);
  localparam int CW       = $clog2(HALF_MAX + 1);

  logic [CW-1:0] clampedLen;
  logic [CW-1:0] halfLen;
  logic [CW-1:0] cnt;

  always_comb begin
    if (divReq == '0)
      clampedLen = CW'(1);
    else if (divReq > DIV_W'(HALF_MAX))
      clampedLen = CW'(HALF_MAX);
    else
      clampedLen = divReq[CW-1:0];
  end

  assign tick = run && (cnt == halfLen - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfLen <= CW'(1);
      cnt     <= '0;
    end else if (load) begin
      halfLen <= clampedLen;
      cnt     <= '0;
    end else if (run) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + CW'(1);
    end
  end

  // Half period always within [1, HALF_MAX] while running
  assert_half_clamp_R6: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (halfLen >= CW'(1) && halfLen <= CW'(HALF_MAX)));

  // Counter never passes the programmed half period
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cnt < halfLen));

endmodule

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import tps_pkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             tckc,
  output dpStrobe_t        strobe
);
  phase_e           phase;
  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] clampedCnt;
  logic             accept;
  logic             endOfBit;

  assign accept     = start && !busy && (bitCount != '0);
  assign clampedCnt = (bitCount > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : bitCount;
  assign endOfBit   = busy && tick && tckc && (phase == PH_TDO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      tckc     <= 1'b0;
      phase    <= PH_NTDI;
      bitsLeft <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        tckc     <= 1'b0;
        phase    <= PH_NTDI;
        bitsLeft <= clampedCnt;
      end else if (busy && tick) begin
        if (!tckc) begin
          tckc <= 1'b1;
        end else begin
          tckc <= 1'b0;
          case (phase)
            PH_NTDI: phase <= PH_TMS;
            PH_TMS:  phase <= PH_TDO;
            default: begin
              phase    <= PH_NTDI;
              bitsLeft <= bitsLeft - CNT_W'(1);
              if (bitsLeft == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.capture = endOfBit;
    strobe.driveEn = busy && (phase != PH_TDO);
    strobe.selTdi  = (phase == PH_NTDI);
  end

  assert_tck_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tckc);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_follows_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !endOfBit) |=> $stable(bitsLeft));

endmodule

// File: rtl/tps_datapath.sv
module tps_datapath
  import tps_pkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int IDX_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [MAX_BITS-1:0] tmsVec,
  input  logic [MAX_BITS-1:0] tdiVec,
  input  logic                tmscIn,
  output logic                tmscOut,
  output logic                tmscOe,
  output logic [MAX_BITS-1:0] tdoVec
);
  logic [MAX_BITS-1:0] tmsSh;
  logic [MAX_BITS-1:0] tdiSh;
  logic [MAX_BITS-1:0] tdoR;
  logic [IDX_W-1:0]    idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmsSh <= '0;
      tdiSh <= '0;
      tdoR  <= '0;
      idx   <= '0;
    end else if (strobe.load) begin
      tmsSh <= tmsVec;
      tdiSh <= tdiVec;
      tdoR  <= '0;
      idx   <= '0;
    end else if (strobe.capture) begin
      tdoR[idx] <= tmscIn;
      tmsSh     <= tmsSh >> 1;
      tdiSh     <= tdiSh >> 1;
      idx       <= idx + IDX_W'(1);
    end
  end

  assign tmscOut = strobe.selTdi ? ~tdiSh[0] : tmsSh[0];
  assign tmscOe  = strobe.driveEn;
  assign tdoVec  = tdoR;

  // Line is never driven by the probe while TDO is sampled
  assert_release_at_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !tmscOe);

  assert_load_clears_tdo_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (tdoVec == '0));

endmodule

// File: rtl/tps_engine.sv
module tps_engine
  import tps_pkg::*;
#(
  parameter int SYS_HZ     = 100_000_000,
  parameter int MIN_TCK_HZ = 500_000,
  parameter int MAX_BITS   = 32,
  parameter int DIV_W      = 16,
  localparam int CNT_W     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tmsVec,
  input  logic [MAX_BITS-1:0] tdiVec,
  input  logic [CNT_W-1:0]    bitCount,
  input  logic [DIV_W-1:0]    divReq,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] tdoVec,
  output logic                tckc,
  output logic                tmscOut,
  output logic                tmscOe,
  input  logic                tmscIn
);
  dpStrobe_t strobe;
  logic      tick;

  tps_divider #(.SYS_HZ(SYS_HZ), .MIN_TCK_HZ(MIN_TCK_HZ), .DIV_W(DIV_W)) div_i (
    .clk(clk), .rstN(rstN), .load(strobe.load), .run(busy),
    .divReq(divReq), .tick(tick)
  );

  tps_ctrl #(.MAX_BITS(MAX_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .bitCount(bitCount),
    .tick(tick), .busy(busy), .done(done), .tckc(tckc), .strobe(strobe)
  );

  tps_datapath #(.MAX_BITS(MAX_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tmsVec(tmsVec),
    .tdiVec(tdiVec), .tmscIn(tmscIn), .tmscOut(tmscOut),
    .tmscOe(tmscOe), .tdoVec(tdoVec)
  );

  assert_oe_only_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    tmscOe |-> busy);

endmodule

// File: tb/tps_engine_tb_top.sv
`timescale 1ns/1ps
module tps_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tmsVec = '0;
  logic [31:0] tdiVec = '0;
  logic [5:0]  bitCount = '0;
  logic [15:0] divReq = '0;
  logic        busy, done, tckc, tmscOut, tmscOe, tmscIn;
  logic [31:0] tdoVec;
  logic        tgtVal = 1'b0;

  int chk = 0;
  int err = 0;
  bit finished = 1'b0;

  logic [31:0] expTms, expTdi, expTdo;
  int  expN, expH, monBit, monPh;
  bit  monActive = 1'b0;
  longint lastEdge = -1;

  always #5 clk = ~clk;

  assign tmscIn = tmscOe ? tmscOut : tgtVal;

  tps_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .tmsVec(tmsVec), .tdiVec(tdiVec),
    .bitCount(bitCount), .divReq(divReq), .busy(busy), .done(done),
    .tdoVec(tdoVec), .tckc(tckc), .tmscOut(tmscOut), .tmscOe(tmscOe),
    .tmscIn(tmscIn)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Target model: per rising TCKC edge check the active period
  always @(posedge tckc) begin
    if (monActive) begin
      if (monPh == 0) begin
        check(tmscOe == 1'b1, "R2 oe in inverted-TDI period", tmscOe, 1);
        check(tmscOut == ~expTdi[monBit], "R2/R10 inverted TDI bit", tmscOut, ~expTdi[monBit]);
      end else if (monPh == 1) begin
        check(tmscOe == 1'b1, "R2 oe in TMS period", tmscOe, 1);
        check(tmscOut == expTms[monBit], "R2/R10 TMS bit", tmscOut, expTms[monBit]);
      end else begin
        check(tmscOe == 1'b0, "R3 line released in TDO period", tmscOe, 0);
        tgtVal = expTdo[monBit];
        monBit++;
      end
      monPh = (monPh + 1) % 3;
    end
  end

  // Half-period spacing of every TCKC edge
  always @(tckc) begin
    if (monActive) begin
      if (lastEdge >= 0)
        check(($time - lastEdge) == longint'(expH * 10), "R5/R6 half period ns",
              $time - lastEdge, expH * 10);
      lastEdge = $time;
    end
  end

  task automatic runReq(input logic [31:0] tms, input logic [31:0] tdi,
                        input logic [31:0] pat, input int cnt, input int div,
                        input bit intrude);
    int n;
    int cyc;
    n = (cnt > 32) ? 32 : cnt;
    expH = (div == 0) ? 1 : ((div > 100) ? 100 : div);
    expN = n;
    expTms = tms;
    expTdi = tdi;
    expTdo = (n == 32) ? pat : (pat & ((32'h1 << n) - 1));
    monBit = 0;
    monPh = 0;
    lastEdge = -1;
    tgtVal = ~pat[0];
    @(negedge clk);
    tmsVec = tms; tdiVec = tdi; bitCount = 6'(cnt); divReq = 16'(div);
    start = 1'b1;
    lastEdge = $time + 5;  // accept edge starts the first half period
    monActive = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    cyc = 0;
    while (busy) begin
      cyc++;
      if (intrude && cyc == 20) begin
        tmsVec = ~tms; tdiVec = ~tdi; bitCount = 6'd1; divReq = 16'd7;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == 6 * expH * n, intrude ? "R9 busy length unchanged" : "R7 busy length",
          cyc, 6 * expH * n);
    check(done == 1'b1, "R7 done after busy", done, 1);
    check(tdoVec == expTdo, intrude ? "R9 tdo unchanged" : "R4 captured tdo", tdoVec, expTdo);
    check(monBit == n, "R2 three periods per bit", monBit, n);
    check(tckc == 1'b0, "R1 tckc idle low", tckc, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", done, 0);
    monActive = 1'b0;
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    check(tckc == 0 && tmscOe == 0, "R1 reset tckc/oe", {tckc, tmscOe}, 0);
    check(tdoVec == 0, "R1 reset tdoVec", tdoVec, 0);
  endtask

  task automatic testZeroCount();
    @(negedge clk);
    bitCount = 6'd0; divReq = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      check(busy == 0 && tckc == 0 && done == 0, "R8 zero count ignored",
            {busy, tckc, done}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runReq(32'h0000_0015, 32'h0000_000A, 32'hFFFF_FFF3, 5, 3, 1'b0);   // R4 upper bits masked
    runReq(32'h1, 32'h0, 32'h1, 1, 0, 1'b0);                           // R5 div 0 -> H=1
    runReq(32'h2, 32'h3, 32'h2, 2, 1000, 1'b0);                        // R6 clamp to 100
    runReq(32'hA5C3_3C5A, 32'h0F1E_2D3C, 32'hDEAD_BEEF, 32, 2, 1'b0);  // R10 full vector
    runReq(32'h1234_5678, 32'h9ABC_DEF0, 32'h8001_7FFE, 40, 1, 1'b0);  // R8 count clamp
    testZeroCount();
    runReq(32'h0000_00C6, 32'h0000_0039, 32'h0000_00B4, 8, 2, 1'b1);   // R9 start while busy
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", chk, err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk++;
      err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", chk, err);
      $finish;
    end
  end

endmodule